// File: doc/BRIEF.md
# Speculative Result Tag Tracker

This block keeps the status tags for a small window of in-flight instruction slots. Each slot is allocated with up to two source slots. Each slot carries three tags: a provisional tag when it issues under an unresolved branch prediction, a result-present tag once its result has been written, and a poison tag when a faulting load sits anywhere in its dependency chain. Forwarding lets a consumer read a provisional or poisoned producer. Because of that, both tags pass down the whole dependency chain.

A branch resolution carries an epoch number. A confirm clears the provisional tag of that epoch's slots, and the chain below them becomes non-provisional unless another provisional producer still feeds it. A squash frees that epoch's slots and every slot that depends on them. A precise exception on a slot frees that slot and everything allocated after it, whether healthy or poisoned. Slots that are older stay in place. A store slot is allowed to write memory only when its operands are present, it is not provisional and it is not poisoned.

Top module: `spec_tag_tracker`

## Requirements
- R1: After reset every slot is free, and no slot shows result-present, ready, provisional, poison or memory-write permission.
- R2: An allocation into a free slot makes that slot busy on the next cycle, with no result present. A result write sets result-present on the cycle after the write.
- R3: A busy slot is ready when each of its enabled sources (given as slot indices) has a result present or has been released. A slot with no sources is ready at once.
- R4: A slot allocated with the speculative flag is provisional. Any slot that reads a provisional slot, directly or through a chain, is also provisional.
- R5: A confirm for epoch E clears the provisional tag of busy speculative slots of epoch E on the next cycle. Slots of other epochs keep their tag.
- R6: A squash for epoch E frees, on the next cycle, every busy still-speculative slot of epoch E and every slot that transitively depends on one. Other slots are untouched.
- R7: When a confirm and a squash name the same epoch in one cycle, the squash takes effect and the confirm is dropped. With different epochs, both take effect.
- R8: A result write with the fault flag poisons that slot, and every slot that transitively reads it is poisoned, even when that slot's own write is clean.
- R9: The memory-write permission of a slot is high only for a busy store slot that is ready, not provisional and not poisoned.
- R10: An exception on slot K frees K and every slot allocated while K was busy. Slots allocated before K stay busy.
- R11: A retire frees one slot. A freed slot can be reallocated on the next cycle and starts with no stale provisional, poison, result or dependency state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Allocate a slot |
| alloc_idx | input | IW | Slot to allocate |
| alloc_spec | input | 1 | Slot issues under an unresolved prediction |
| alloc_epoch | input | EPW | Branch epoch of the slot |
| alloc_store | input | 1 | Slot is a memory store |
| src_a_en | input | 1 | First source is used |
| src_a_idx | input | IW | First source slot |
| src_b_en | input | 1 | Second source is used |
| src_b_idx | input | IW | Second source slot |
| wr_en | input | 1 | Result write |
| wr_idx | input | IW | Slot being written |
| wr_fault | input | 1 | Written result comes from a faulting load |
| cfm_en | input | 1 | Prediction confirmed |
| cfm_epoch | input | EPW | Epoch being confirmed |
| sqs_en | input | 1 | Prediction wrong, squash |
| sqs_epoch | input | EPW | Epoch being squashed |
| exc_en | input | 1 | Exception taken |
| exc_idx | input | IW | Faulting slot |
| ret_en | input | 1 | Retire a slot |
| ret_idx | input | IW | Slot to retire |
| free_o | output | NSLOT | Slot is free for allocation |
| valid_o | output | NSLOT | Slot result present |
| ready_o | output | NSLOT | Slot operands available |
| prov_o | output | NSLOT | Slot provisional |
| poison_o | output | NSLOT | Slot poisoned |
| memok_o | output | NSLOT | Slot may write memory |

## Verification
The checks assume well-formed control. An allocation targets a free slot, its sources are busy slots other than itself, and no allocation arrives in a cycle that carries a squash or an exception. Writes, retires and exceptions name busy slots, and a consumer is written only after its producers. The directed tasks obey these rules: each task frees its slots with an exception on its oldest slot or with retires before the next task starts, and it never mixes an allocation with a kill event. Two of the properties check the allocation rules directly, so a stimulus that breaks them shows up at once.

// File: rtl/spec_tag_tracker.sv
module spec_tag_tracker #(
  parameter int NSLOT = 8,
  parameter int EPW = 3,
  localparam int IW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IW-1:0]    alloc_idx,
  input  logic             alloc_spec,
  input  logic [EPW-1:0]   alloc_epoch,
  input  logic             alloc_store,
  input  logic             src_a_en,
  input  logic [IW-1:0]    src_a_idx,
  input  logic             src_b_en,
  input  logic [IW-1:0]    src_b_idx,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_fault,
  input  logic             cfm_en,
  input  logic [EPW-1:0]   cfm_epoch,
  input  logic             sqs_en,
  input  logic [EPW-1:0]   sqs_epoch,
  input  logic             exc_en,
  input  logic [IW-1:0]    exc_idx,
  input  logic             ret_en,
  input  logic [IW-1:0]    ret_idx,
  output logic [NSLOT-1:0] free_o,
  output logic [NSLOT-1:0] valid_o,
  output logic [NSLOT-1:0] ready_o,
  output logic [NSLOT-1:0] prov_o,
  output logic [NSLOT-1:0] poison_o,
  output logic [NSLOT-1:0] memok_o
);

  logic [NSLOT-1:0] busy, done, spec, fault, store;
  logic [EPW-1:0]   ep    [NSLOT];
  logic [NSLOT-1:0] srcm  [NSLOT];
  logic [NSLOT-1:0] deps  [NSLOT];
  logic [NSLOT-1:0] older [NSLOT];

  logic [NSLOT-1:0] sq_root, cf_hit, kill, rel, ret_oh, a_oh, b_oh, new_src, new_deps;
  logic cf_ok;

  assign cf_ok  = cfm_en && !(sqs_en && sqs_epoch == cfm_epoch);
  assign ret_oh = ret_en ? (NSLOT'(1) << ret_idx) : '0;
  assign a_oh   = src_a_en ? (NSLOT'(1) << src_a_idx) : '0;
  assign b_oh   = src_b_en ? (NSLOT'(1) << src_b_idx) : '0;
  assign new_src  = a_oh | b_oh;
  assign new_deps = new_src | (src_a_en ? deps[src_a_idx] : '0)
                            | (src_b_en ? deps[src_b_idx] : '0);

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      sq_root[i] = sqs_en && busy[i] && spec[i] && ep[i] == sqs_epoch;
      cf_hit[i]  = cf_ok && busy[i] && spec[i] && ep[i] == cfm_epoch;
    end
    for (int i = 0; i < NSLOT; i++)
      kill[i] = busy[i] && (sq_root[i] || |(deps[i] & sq_root) ||
                (exc_en && (exc_idx == IW'(i) || older[i][exc_idx])));
    rel = kill | ret_oh;
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      prov_o[i]   = busy[i] && (spec[i]  || |(deps[i] & spec));
      poison_o[i] = busy[i] && (fault[i] || |(deps[i] & fault));
      ready_o[i]  = busy[i] && !(|(srcm[i] & busy & ~done));
      memok_o[i]  = store[i] && ready_o[i] && !prov_o[i] && !poison_o[i];
    end
  end

  assign free_o  = ~busy;
  assign valid_o = busy & done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      done  <= '0;
      spec  <= '0;
      fault <= '0;
      store <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        ep[i]    <= '0;
        srcm[i]  <= '0;
        deps[i]  <= '0;
        older[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (rel[i]) begin
          busy[i]  <= 1'b0;
          done[i]  <= 1'b0;
          spec[i]  <= 1'b0;
          fault[i] <= 1'b0;
          store[i] <= 1'b0;
          srcm[i]  <= '0;
          deps[i]  <= '0;
          older[i] <= '0;
        end else if (alloc_en && alloc_idx == IW'(i)) begin
          busy[i]  <= 1'b1;
          done[i]  <= 1'b0;
          spec[i]  <= alloc_spec;
          fault[i] <= 1'b0;
          store[i] <= alloc_store;
          ep[i]    <= alloc_epoch;
          srcm[i]  <= new_src & ~rel;
          deps[i]  <= new_deps & ~rel;
          older[i] <= busy & ~rel;
        end else begin
          srcm[i]  <= srcm[i] & ~rel;
          deps[i]  <= deps[i] & ~rel;
          older[i] <= older[i] & ~rel;
          if (wr_en && wr_idx == IW'(i)) begin
            done[i]  <= 1'b1;
            fault[i] <= wr_fault;
          end
          if (cf_hit[i]) spec[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/spec_tag_tracker_chk.sv
module spec_tag_tracker_chk #(
  parameter int NSLOT = 8,
  parameter int EPW = 3,
  localparam int IW = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_en,
  input logic [IW-1:0]    alloc_idx,
  input logic             alloc_spec,
  input logic [EPW-1:0]   alloc_epoch,
  input logic             alloc_store,
  input logic             src_a_en,
  input logic [IW-1:0]    src_a_idx,
  input logic             src_b_en,
  input logic [IW-1:0]    src_b_idx,
  input logic             wr_en,
  input logic [IW-1:0]    wr_idx,
  input logic             wr_fault,
  input logic             cfm_en,
  input logic [EPW-1:0]   cfm_epoch,
  input logic             sqs_en,
  input logic [EPW-1:0]   sqs_epoch,
  input logic             exc_en,
  input logic [IW-1:0]    exc_idx,
  input logic             ret_en,
  input logic [IW-1:0]    ret_idx,
  input logic [NSLOT-1:0] free_o,
  input logic [NSLOT-1:0] valid_o,
  input logic [NSLOT-1:0] ready_o,
  input logic [NSLOT-1:0] prov_o,
  input logic [NSLOT-1:0] poison_o,
  input logic [NSLOT-1:0] memok_o
);

  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_o[alloc_idx]);

  assert_alloc_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en && !sqs_en && !exc_en |=> !free_o[$past(alloc_idx)]);

  assert_no_alloc_on_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sqs_en || exc_en) |-> !alloc_en);

  assert_fault_poisons_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_fault && !sqs_en && !exc_en && !(ret_en && ret_idx == wr_idx)
    |=> poison_o[$past(wr_idx)] && !memok_o[$past(wr_idx)]);

  assert_exc_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en |=> free_o[$past(exc_idx)]);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assert_prov_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prov_o[i]) |-> $past(cfm_en || sqs_en || exc_en || ret_en));
  end

endmodule

bind spec_tag_tracker spec_tag_tracker_chk #(.NSLOT(NSLOT), .EPW(EPW)) u_chk (.*);

// File: tb/spec_tag_tracker_tb.sv
`timescale 1ns/1ps
module spec_tag_tracker_tb;
  localparam int NSLOT = 8;
  localparam int EPW = 3;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic alloc_en = 0, alloc_spec = 0, alloc_store = 0;
  logic [IW-1:0] alloc_idx = '0, src_a_idx = '0, src_b_idx = '0, wr_idx = '0, exc_idx = '0, ret_idx = '0;
  logic [EPW-1:0] alloc_epoch = '0, cfm_epoch = '0, sqs_epoch = '0;
  logic src_a_en = 0, src_b_en = 0, wr_en = 0, wr_fault = 0;
  logic cfm_en = 0, sqs_en = 0, exc_en = 0, ret_en = 0;
  logic [NSLOT-1:0] free_o, valid_o, ready_o, prov_o, poison_o, memok_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spec_tag_tracker #(.NSLOT(NSLOT), .EPW(EPW)) u_dut (.*);

  task automatic tick();
    @(posedge clk); #1;
    alloc_en = 0; src_a_en = 0; src_b_en = 0; wr_en = 0; wr_fault = 0;
    cfm_en = 0; sqs_en = 0; exc_en = 0; ret_en = 0;
  endtask

  task automatic chk(string req, string what, logic [NSLOT-1:0] act, logic [NSLOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic alloc(int idx, bit sp, int e, bit st, bit ae = 0, int a = 0, bit be = 0, int b = 0);
    alloc_en = 1; alloc_idx = IW'(idx); alloc_spec = sp; alloc_epoch = EPW'(e);
    alloc_store = st; src_a_en = ae; src_a_idx = IW'(a); src_b_en = be; src_b_idx = IW'(b);
    tick();
  endtask

  task automatic wr(int idx, bit f);
    wr_en = 1; wr_idx = IW'(idx); wr_fault = f; tick();
  endtask

  task automatic flush(int idx);
    exc_en = 1; exc_idx = IW'(idx); tick();
  endtask

  task automatic retire(int idx);
    ret_en = 1; ret_idx = IW'(idx); tick();
  endtask

  task automatic t_reset();
    chk("R1", "free", free_o, 8'hFF);
    chk("R1", "valid", valid_o, 8'h00);
    chk("R1", "ready", ready_o, 8'h00);
    chk("R1", "prov", prov_o, 8'h00);
    chk("R1", "poison", poison_o, 8'h00);
    chk("R1", "memok", memok_o, 8'h00);
  endtask

  task automatic t_basic();
    alloc(0, 0, 0, 0);
    chk("R2", "free after alloc", free_o, 8'hFE);
    chk("R2", "valid before write", valid_o, 8'h00);
    chk("R3", "ready no sources", ready_o, 8'h01);
    alloc(1, 0, 0, 1, 1, 0);
    chk("R3", "consumer waits", ready_o, 8'h01);
    chk("R9", "store not ready", memok_o, 8'h00);
    wr(0, 0);
    chk("R2", "valid after write", valid_o, 8'h01);
    chk("R3", "consumer ready", ready_o, 8'h03);
    chk("R9", "store allowed", memok_o, 8'h02);
    retire(0);
    chk("R11", "retire frees", free_o, 8'hFD);
    chk("R3", "released source", ready_o, 8'h02);
    retire(1);
    chk("R11", "all free", free_o, 8'hFF);
  endtask

  task automatic t_prov();
    alloc(0, 1, 2, 0);
    alloc(1, 0, 0, 0, 1, 0);
    alloc(2, 0, 0, 1, 1, 1);
    alloc(3, 1, 3, 0);
    chk("R4", "chain provisional", prov_o, 8'h0F);
    wr(0, 0);
    wr(1, 0);
    chk("R9", "provisional store blocked", memok_o, 8'h00);
    cfm_en = 1; cfm_epoch = 3'd2; tick();
    chk("R5", "confirm epoch 2 only", prov_o, 8'h08);
    chk("R9", "confirmed store allowed", memok_o, 8'h04);
    sqs_en = 1; sqs_epoch = 3'd3; tick();
    chk("R6", "squash epoch 3", free_o, 8'hF8);
    flush(0);
    chk("R10", "flush from oldest", free_o, 8'hFF);
  endtask

  task automatic t_squash();
    alloc(0, 0, 0, 0);
    alloc(1, 1, 1, 0);
    alloc(2, 0, 0, 0, 1, 1);
    alloc(3, 0, 0, 1, 1, 2);
    alloc(4, 0, 0, 0, 1, 0);
    wr(0, 0);
    wr(1, 0);
    chk("R4", "provisional chain", prov_o, 8'h0E);
    sqs_en = 1; sqs_epoch = 3'd1; tick();
    chk("R6", "chain freed", free_o, 8'hEE);
    chk("R6", "no provisional left", prov_o, 8'h00);
    alloc(2, 0, 0, 0, 1, 0);
    chk("R11", "realloc busy", free_o, 8'hEA);
    chk("R11", "realloc clean prov", prov_o, 8'h00);
    chk("R11", "realloc clean valid", valid_o, 8'h01);
    chk("R11", "realloc ready", ready_o, 8'h15);
    flush(0);
    chk("R10", "cleanup", free_o, 8'hFF);
  endtask

  task automatic t_both();
    alloc(5, 1, 4, 0);
    alloc(6, 1, 5, 0);
    cfm_en = 1; cfm_epoch = 3'd4; sqs_en = 1; sqs_epoch = 3'd4; tick();
    chk("R7", "squash wins free", free_o, 8'hBF);
    chk("R7", "squash wins prov", prov_o, 8'h40);
    cfm_en = 1; cfm_epoch = 3'd5; sqs_en = 1; sqs_epoch = 3'd4; tick();
    chk("R7", "distinct epochs prov", prov_o, 8'h00);
    chk("R7", "distinct epochs free", free_o, 8'hBF);
    flush(6);
    chk("R10", "cleanup", free_o, 8'hFF);
  endtask

  task automatic t_poison();
    alloc(7, 0, 0, 0);
    alloc(0, 0, 0, 0);
    alloc(1, 0, 0, 1, 1, 0);
    alloc(2, 0, 0, 1, 1, 1);
    alloc(3, 0, 0, 1);
    chk("R9", "healthy store", memok_o, 8'h08);
    wr(0, 1);
    chk("R8", "poison spread", poison_o, 8'h07);
    wr(1, 0);
    chk("R8", "clean write stays poisoned", poison_o, 8'h07);
    chk("R9", "poisoned stores blocked", memok_o, 8'h08);
    flush(0);
    chk("R10", "younger flushed older kept", free_o, 8'h7F);
    chk("R10", "no poison left", poison_o, 8'h00);
    retire(7);
    chk("R11", "cleanup", free_o, 8'hFF);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_prov();
    t_squash();
    t_both();
    t_poison();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule